// File: doc/BRIEF.md
# Link-Protection Receiver Register File

This block is the byte-addressed register space of a content-protection receiver. An upstream transmitter reaches it over the display data channel. An external I2C slave turns each bus transfer into a single-cycle byte read or byte write on a simple memory-mapped port. The block decodes the address and applies the access rules. A read returns either a live value supplied by neighbouring logic, or zero.

From the receiver side, the register file exposes the receiver key selection vector, the link verification response Ri', five 32-bit repeater hash words, a capability byte and two topology status bytes. The transmitter writes its own 40-bit key selection vector and the 64-bit session random number. These values are stored and driven out to the authentication engine. Writing the top byte of the transmitter key raises a one-cycle strobe that starts authentication.

A fixed address gives access to a repeater key-list FIFO whose storage lives outside the block. The block owns the read pointer. It advances the pointer on each read of a non-empty FIFO and rewinds it whenever the list-ready indication rises. The cipher, the hash engine and the key derivation are outside the block and appear only as inputs.

Top module: `linkprot_rx_regs`

## Requirements
- R1: A read of 0x00..0x04 returns byte n of rxKsv (0x00 = bits 7:0, up to 0x04 = bits 39:32). A read of 0x08 returns riPrime[7:0] and a read of 0x09 returns riPrime[15:8].
- R2: A read of 0x20..0x33 returns byte (addr-0x20) of hashWords. Word k occupies hashWords[32k+31:32k], and each word is read least significant byte first.
- R3: A write to 0x10..0x14 stores byte (addr-0x10) of txKsv. A write to 0x18..0x1F stores byte (addr-0x18) of anValue. Both are least significant byte first and appear on the outputs the cycle after the write. Reads of these addresses return 0x00.
- R4: aksvWritten is high for exactly one cycle, the cycle after a write to 0x14. No other write raises it.
- R5: A read of 0x40 returns {hdmiCapable, isRepeater, listReady & ~hashBusy, 4'b0000, 1'b1}.
- R6: A read of 0x41 returns {devTooMany, devCount[6:0]}. A read of 0x42 returns {2'b00, 1'b0, hdmiMode, cascadeTooMany, cascadeDepth[2:0]}.
- R7: When fifoRdPtr < fifoLevel, a read of 0x43 returns fifoRdByte and then increments fifoRdPtr by one. When the FIFO is empty, the read returns 0x00 and fifoRdPtr does not change.
- R8: fifoRdPtr returns to 0 on the clock edge after the ready bit (listReady & ~hashBusy) goes from 0 to 1. The rewind takes precedence over a pop at the same edge.
- R9: Every address not named in R1..R3 and R5..R7 reads 0x00. A write to any address outside the ranges in R3 changes neither txKsv nor anValue.
- R10: busRdData is loaded on the clock edge that samples busRead and holds its value between reads. After reset, busRdData, txKsv, anValue, aksvWritten and fifoRdPtr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address |
| busRead | input | 1 | Single-cycle read request |
| busWrite | input | 1 | Single-cycle write request |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, registered |
| rxKsv | input | 40 | Receiver key selection vector |
| riPrime | input | 16 | Link verification response |
| hashWords | input | 160 | Five repeater hash words, word 0 lowest |
| hdmiCapable | input | 1 | Capability flag |
| isRepeater | input | 1 | Repeater flag |
| listReady | input | 1 | Key list and hash complete |
| hashBusy | input | 1 | Hash computation in progress |
| devTooMany | input | 1 | Device-count overflow |
| devCount | input | 7 | Downstream device count |
| hdmiMode | input | 1 | Link in HDMI mode |
| cascadeTooMany | input | 1 | Cascade-depth overflow |
| cascadeDepth | input | 3 | Cascade depth |
| fifoLevel | input | 10 | Bytes available in the key-list FIFO |
| fifoRdByte | input | 8 | FIFO byte at fifoRdPtr |
| fifoRdPtr | output | 10 | FIFO read pointer |
| txKsv | output | 40 | Stored transmitter key selection vector |
| anValue | output | 64 | Stored session random number |
| aksvWritten | output | 1 | Authentication start strobe |

## Verification
The assertions assume that busRead and busWrite are never high in the same cycle. The external I2C slave issues one transfer at a time, and the bench tasks drive only one of the two strobes per cycle. They also assume fifoLevel never exceeds the pointer range. The bench keeps fifoLevel at or below 1023 and holds the ready inputs steady during the random phase, so that the pointer model changes only through the directed rewind cases.

// File: rtl/linkprot_rx_pkg.sv
package linkprot_rx_pkg;
  parameter int KSV_BYTES  = 5;
  parameter int AN_BYTES   = 8;
  parameter int HASH_WORDS = 5;
  localparam int KSV_W   = KSV_BYTES * 8;
  localparam int AN_W    = AN_BYTES * 8;
  localparam int HASH_W  = HASH_WORDS * 32;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_BKSV, SEL_RI, SEL_HASH,
    SEL_CAPS, SEL_STAT0, SEL_STAT1, SEL_FIFO
  } rdSel_e;

  typedef struct packed {
    logic       txKsvWr;
    logic       anWr;
    logic [2:0] wrIdx;
    logic       aksvDone;
    logic       rdEn;
    rdSel_e     rdSel;
    logic [4:0] rdIdx;
    logic       fifoPop;
  } lpStrobes_t;
endpackage

// File: rtl/linkprot_rx_ctrl.sv
module linkprot_rx_ctrl
  import linkprot_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busRead,
  input  logic       busWrite,
  input  logic       fifoEmpty,
  output lpStrobes_t strobes
);
  rdSel_e selNext;

  always_comb begin
    selNext = SEL_ZERO;
    if (busAddr <= 8'h04)                        selNext = SEL_BKSV;
    else if (busAddr == 8'h08 || busAddr == 8'h09) selNext = SEL_RI;
    else if (busAddr >= 8'h20 && busAddr <= 8'h33) selNext = SEL_HASH;
    else if (busAddr == 8'h40)                   selNext = SEL_CAPS;
    else if (busAddr == 8'h41)                   selNext = SEL_STAT0;
    else if (busAddr == 8'h42)                   selNext = SEL_STAT1;
    else if (busAddr == 8'h43)                   selNext = SEL_FIFO;
  end

  always_comb begin
    strobes          = '0;
    strobes.wrIdx    = busAddr[2:0];
    strobes.rdIdx    = busAddr[4:0];
    strobes.rdSel    = selNext;
    strobes.rdEn     = busRead;
    strobes.txKsvWr  = busWrite && busAddr >= 8'h10 && busAddr <= 8'h14;
    strobes.anWr     = busWrite && busAddr >= 8'h18 && busAddr <= 8'h1F;
    strobes.aksvDone = busWrite && busAddr == 8'h14;
    strobes.fifoPop  = busRead && selNext == SEL_FIFO && !fifoEmpty;
  end

  // single transfer per cycle from the bus bridge
  p_one_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));
endmodule

// File: rtl/linkprot_rx_dp.sv
module linkprot_rx_dp
  import linkprot_rx_pkg::*;
#(
  parameter int FIFO_PTR_W = 10
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  lpStrobes_t            strobes,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  input  logic [KSV_W-1:0]      rxKsv,
  input  logic [15:0]           riPrime,
  input  logic [HASH_W-1:0]     hashWords,
  input  logic                  hdmiCapable,
  input  logic                  isRepeater,
  input  logic                  listReady,
  input  logic                  hashBusy,
  input  logic                  devTooMany,
  input  logic [6:0]            devCount,
  input  logic                  hdmiMode,
  input  logic                  cascadeTooMany,
  input  logic [2:0]            cascadeDepth,
  input  logic [FIFO_PTR_W-1:0] fifoLevel,
  input  logic [7:0]            fifoRdByte,
  output logic [FIFO_PTR_W-1:0] fifoRdPtr,
  output logic                  fifoEmpty,
  output logic [KSV_W-1:0]      txKsv,
  output logic [AN_W-1:0]       anValue,
  output logic                  aksvWritten
);
  logic [7:0] txKsvB [KSV_BYTES];
  logic [7:0] anB    [AN_BYTES];
  logic [7:0] rdMux;
  logic       readyBit, readyQ, rewind;

  for (genvar b = 0; b < KSV_BYTES; b++) begin : g_ksv
    always_ff @(posedge clk) begin
      if (!rstN) txKsvB[b] <= '0;
      else if (strobes.txKsvWr && strobes.wrIdx == 3'(b)) txKsvB[b] <= busWrData;
    end
    assign txKsv[b*8 +: 8] = txKsvB[b];
  end

  for (genvar b = 0; b < AN_BYTES; b++) begin : g_an
    always_ff @(posedge clk) begin
      if (!rstN) anB[b] <= '0;
      else if (strobes.anWr && strobes.wrIdx == 3'(b)) anB[b] <= busWrData;
    end
    assign anValue[b*8 +: 8] = anB[b];
  end

  assign readyBit  = listReady & ~hashBusy;
  assign rewind    = readyBit & ~readyQ;
  assign fifoEmpty = fifoRdPtr >= fifoLevel;

  always_comb begin
    case (strobes.rdSel)
      SEL_BKSV:  rdMux = rxKsv[strobes.rdIdx[2:0]*8 +: 8];
      SEL_RI:    rdMux = strobes.rdIdx[0] ? riPrime[15:8] : riPrime[7:0];
      SEL_HASH:  rdMux = hashWords[strobes.rdIdx*8 +: 8];
      SEL_CAPS:  rdMux = {hdmiCapable, isRepeater, readyBit, 4'b0000, 1'b1};
      SEL_STAT0: rdMux = {devTooMany, devCount};
      SEL_STAT1: rdMux = {3'b000, hdmiMode, cascadeTooMany, cascadeDepth};
      SEL_FIFO:  rdMux = fifoEmpty ? 8'h00 : fifoRdByte;
      default:   rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData   <= '0;
      fifoRdPtr   <= '0;
      readyQ      <= 1'b0;
      aksvWritten <= 1'b0;
    end else begin
      readyQ      <= readyBit;
      aksvWritten <= strobes.aksvDone;
      if (strobes.rdEn) busRdData <= rdMux;
      if (rewind) fifoRdPtr <= '0;
      else if (strobes.fifoPop) fifoRdPtr <= fifoRdPtr + 1'b1;
    end
  end

  p_aksv_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    aksvWritten |=> !aksvWritten);
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fifoRdPtr) |-> (fifoRdPtr == $past(fifoRdPtr) + 1'b1 || fifoRdPtr == '0));
  p_ptr_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !rewind) |=> $stable(fifoRdPtr));
  p_caps_const_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn && strobes.rdSel == SEL_CAPS) |=> (busRdData[0] && busRdData[4:1] == 4'b0));
  p_txksv_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.txKsvWr |=> $stable(txKsv));
  p_an_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.anWr |=> $stable(anValue));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> $stable(busRdData));
endmodule

// File: rtl/linkprot_rx_regs.sv
module linkprot_rx_regs
  import linkprot_rx_pkg::*;
#(
  parameter int FIFO_PTR_W = 10
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [7:0]            busAddr,
  input  logic                  busRead,
  input  logic                  busWrite,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  input  logic [KSV_W-1:0]      rxKsv,
  input  logic [15:0]           riPrime,
  input  logic [HASH_W-1:0]     hashWords,
  input  logic                  hdmiCapable,
  input  logic                  isRepeater,
  input  logic                  listReady,
  input  logic                  hashBusy,
  input  logic                  devTooMany,
  input  logic [6:0]            devCount,
  input  logic                  hdmiMode,
  input  logic                  cascadeTooMany,
  input  logic [2:0]            cascadeDepth,
  input  logic [FIFO_PTR_W-1:0] fifoLevel,
  input  logic [7:0]            fifoRdByte,
  output logic [FIFO_PTR_W-1:0] fifoRdPtr,
  output logic [KSV_W-1:0]      txKsv,
  output logic [AN_W-1:0]       anValue,
  output logic                  aksvWritten
);
  lpStrobes_t strobes;
  logic       fifoEmpty;

  linkprot_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .fifoEmpty(fifoEmpty), .strobes(strobes)
  );

  linkprot_rx_dp #(.FIFO_PTR_W(FIFO_PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .busRdData(busRdData), .rxKsv(rxKsv), .riPrime(riPrime),
    .hashWords(hashWords), .hdmiCapable(hdmiCapable), .isRepeater(isRepeater),
    .listReady(listReady), .hashBusy(hashBusy), .devTooMany(devTooMany),
    .devCount(devCount), .hdmiMode(hdmiMode), .cascadeTooMany(cascadeTooMany),
    .cascadeDepth(cascadeDepth), .fifoLevel(fifoLevel), .fifoRdByte(fifoRdByte),
    .fifoRdPtr(fifoRdPtr), .fifoEmpty(fifoEmpty), .txKsv(txKsv),
    .anValue(anValue), .aksvWritten(aksvWritten)
  );
endmodule

// File: tb/linkprot_rx_regs_bench.sv
`timescale 1ns/1ps
module linkprot_rx_regs_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   busAddr = '0, busWrData = '0;
  logic         busRead = 1'b0, busWrite = 1'b0;
  logic [7:0]   busRdData;
  logic [39:0]  rxKsv = '0;
  logic [15:0]  riPrime = '0;
  logic [159:0] hashWords = '0;
  logic         hdmiCapable = 0, isRepeater = 0, listReady = 0, hashBusy = 0;
  logic         devTooMany = 0, hdmiMode = 0, cascadeTooMany = 0;
  logic [6:0]   devCount = '0;
  logic [2:0]   cascadeDepth = '0;
  logic [9:0]   fifoLevel = '0;
  logic [7:0]   fifoRdByte;
  logic [9:0]   fifoRdPtr;
  logic [39:0]  txKsv;
  logic [63:0]  anValue;
  logic         aksvWritten;

  logic [7:0]   fifoMem [1024];
  logic [39:0]  mKsv = '0;
  logic [63:0]  mAn = '0;
  int unsigned  mPtr = 0;
  int           nChk = 0, nBad = 0;
  bit           done = 0;
  int unsigned  seed = 32'h5eed_1234;

  always #4 clk = ~clk;
  assign fifoRdByte = fifoMem[fifoRdPtr];

  linkprot_rx_regs u_linkprot_rx_regs (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [7:0] a);
    if (a <= 8'h04) return rxKsv[a*8 +: 8];
    if (a == 8'h08) return riPrime[7:0];
    if (a == 8'h09) return riPrime[15:8];
    if (a >= 8'h20 && a <= 8'h33) return hashWords[(a-8'h20)*8 +: 8];
    if (a == 8'h40) return {hdmiCapable, isRepeater, listReady & ~hashBusy, 4'b0, 1'b1};
    if (a == 8'h41) return {devTooMany, devCount};
    if (a == 8'h42) return {3'b0, hdmiMode, cascadeTooMany, cascadeDepth};
    if (a == 8'h43) return (mPtr < fifoLevel) ? fifoMem[mPtr] : 8'h00;
    return 8'h00;
  endfunction

  function automatic string tagOf(logic [7:0] a);
    if (a <= 8'h09 && a != 8'h05 && a != 8'h06 && a != 8'h07) return "R1";
    if (a >= 8'h20 && a <= 8'h33) return "R2";
    if ((a >= 8'h10 && a <= 8'h14) || (a >= 8'h18 && a <= 8'h1F)) return "R3";
    if (a == 8'h40) return "R5";
    if (a == 8'h41 || a == 8'h42) return "R6";
    if (a == 8'h43) return "R7";
    return "R9";
  endfunction

  task automatic doRead(logic [7:0] a);
    logic [7:0] e;
    e = expRead(a);
    @(negedge clk); busAddr = a; busRead = 1'b1;
    @(negedge clk); busRead = 1'b0;
    if (a == 8'h43 && mPtr < fifoLevel) mPtr++;
    check(tagOf(a), busRdData, e);
    if (a == 8'h43) check("R7 ptr", fifoRdPtr, mPtr);
  endtask

  task automatic doWrite(logic [7:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
    if (a >= 8'h10 && a <= 8'h14) mKsv[(a-8'h10)*8 +: 8] = d;
    if (a >= 8'h18 && a <= 8'h1F) mAn[(a-8'h18)*8 +: 8] = d;
    check("R3 ksv / R9", txKsv, mKsv);
    check("R3 an / R9", anValue, mAn);
    check("R4 strobe", aksvWritten, a == 8'h14);
  endtask

  task automatic randInputs();
    rxKsv = {8'($urandom), $urandom};
    riPrime = 16'($urandom);
    for (int i = 0; i < 5; i++) hashWords[i*32 +: 32] = $urandom;
    {hdmiCapable, isRepeater, devTooMany, hdmiMode, cascadeTooMany} = 5'($urandom);
    devCount = 7'($urandom);
    cascadeDepth = 3'($urandom);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    for (int i = 0; i < 1024; i++) fifoMem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 rd", busRdData, 0);
    check("R10 ksv", txKsv, 0);
    check("R10 an", anValue, 0);
    check("R10 strobe", aksvWritten, 0);
    check("R10 ptr", fifoRdPtr, 0);
    rstN = 1'b1;
    @(negedge clk);

    randInputs();
    for (int a = 0; a < 256; a++) doRead(8'(a));   // full sweep, FIFO empty
    // R10 hold: no read keeps data
    doRead(8'h41);
    repeat (3) @(negedge clk);
    check("R10 hold", busRdData, {devTooMany, devCount});

    // R3/R4 directed
    for (int b = 0; b < 5; b++) doWrite(8'(8'h10 + b), 8'(8'hA0 + b));
    @(negedge clk);
    check("R4 one cycle", aksvWritten, 0);
    for (int b = 0; b < 8; b++) doWrite(8'(8'h18 + b), 8'(8'h50 + b));
    doRead(8'h12);
    doRead(8'h1C);
    doWrite(8'h00, 8'hFF);
    doWrite(8'h15, 8'hFF);
    doRead(8'h00);

    // R5 ready bit with hash busy
    listReady = 1; hashBusy = 1;
    doRead(8'h40);
    // R7 FIFO pops
    fifoLevel = 10'd6;
    for (int i = 0; i < 8; i++) doRead(8'h43);
    check("R7 empty hold", fifoRdPtr, 6);
    // R8 rewind on ready rise
    hashBusy = 0;
    @(negedge clk); @(negedge clk);
    mPtr = 0;
    check("R8 rewind", fifoRdPtr, 0);
    doRead(8'h40);
    fifoLevel = 10'd900;
    for (int i = 0; i < 20; i++) doRead(8'h43);
    // R8 rewind wins over same-edge pop
    hashBusy = 1;
    @(negedge clk); @(negedge clk);
    begin
      logic [7:0] e;
      e = fifoMem[mPtr];
      @(negedge clk); hashBusy = 0; busAddr = 8'h43; busRead = 1'b1;
      @(negedge clk); busRead = 1'b0;
      mPtr = 0;
      check("R8 data", busRdData, e);
      check("R8 rewind wins", fifoRdPtr, 0);
    end

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if ($urandom % 4 == 0) a = 8'h43;
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0) a = 8'(8'h10 + $urandom % 16);
        doWrite(a, 8'($urandom));
      end else begin
        if ($urandom % 8 == 0) randInputs();
        doRead(a);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule